// File: doc/BRIEF.md
# Single-Wire Pulse-Width Bus Master

This block is a bus master for a single-wire, open-drain link of the kind used to talk to battery fuel gauges. Software reaches it through a small byte-wide register port. It loads a byte to send, or asks for a byte to be received, or asks for a bus-reset break. It then sets a start bit in the control register. The block encodes each bit as a low pulse whose width carries the value. It measures the widths of the pulses the slave returns and builds them into a byte. When an operation finishes it raises a flag in a clear-on-read event register. An interrupt line follows those flags when the interrupt enable is set.

The line is never driven high. The block drives a pull-down enable and reads the wire back through a synchroniser. Pulse widths, the break length, the recovery time and the receive timeout are parameters counted in functional clock cycles. A soft reset bit returns the whole block to its reset state without touching the hardware reset.

Top module: `swb_master`

## Requirements
- R1: After reset these registers read as follows: revision (0x00) reads {REV_MAJOR, REV_MINOR} = 0x21, control (0x0C) reads 0x00, events (0x10) reads 0x00 and system status (0x18) reads 0x01. The outputs `line_pd` and `irq` are 0.
- R2: A send starts when control is written with start (bit 4) and clock enable (bit 5) set while init (bit 2) and direction (bit 1) are 0. Starting on the edge that takes that write, the byte in TX data (0x04) goes out LSB first. Each bit lasts T_BIT = 24 cycles. A 1 is pulled low for T_ONE = 4 cycles and a 0 for T_ZERO = 16 cycles, then the line is released for the rest of the bit.
- R3: The send-done event (bit 2 of 0x10) becomes visible 8*T_BIT cycles after the start edge.
- R4: A start written with init = 1 issues a break. The line is pulled low for T_BRK = 20 cycles and then released for T_REC = 10 cycles. The timeout event (bit 0) becomes visible T_BRK+T_REC cycles after the start edge.
- R5: A start written with direction = 1 (init 0) receives a byte. Each low pulse from the slave is measured. A pulse shorter than (T_ONE+T_ZERO)/2 cycles is a 1, and any other pulse is a 0. The bits are assembled LSB first into RX data (0x08) and the receive-done event (bit 1) is set. The block never pulls the line down while receiving.
- R6: If no low pulse begins within RX_TMO = 64 cycles of the receive start (or of the end of the previous bit), the receive ends with the timeout event (bit 0) and no receive-done event.
- R7: Reading the event register returns the pending events and clears them. An event that completes on the same edge as that read stays set.
- R8: `irq` is 1 exactly when the interrupt enable (control bit 6) is 1 and at least one event bit is set.
- R9: At the end of an operation, start and init return to 0 only when the interrupt enable is 1. Otherwise they stay set. Direction is never cleared by the block.
- R10: No operation starts if clock enable is 0 in the written value. No operation starts while one is in progress. A control write during an operation changes only interrupt enable, clock enable and mode (bit 0).
- R11: Writing 1 to system configuration bit 1 (0x14) resets all registers, the events and the engine one cycle later. System status bit 0 reads 0 during that cycle and 1 again afterwards.
- R12: System configuration bit 0 is stored and reads back, with no effect on bus behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears events when addressing 0x10) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| line_in | input | 1 | Sensed level of the bus wire (asynchronous) |
| line_pd | output | 1 | Pull-down enable for the open-drain wire |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the register strobes are single-cycle and that software does not assert a write and a read in the same cycle. They also assume a slave starts each reply pulse only after the master has released the wire, so the receive engine never sees the master's own pull-down. The stimulus holds each strobe for exactly one cycle and leaves an idle cycle between accesses. The modelled slave drives `line_in` only while a receive is open, with its first pulse well inside the timeout window. Reads of the event register are placed only after the engine has gone idle, so the model never has to settle a read and a completion on the same edge.

// File: rtl/swb_pkg.sv
package swb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_BRK_LO, ST_BRK_HI, ST_TX_LO, ST_TX_HI, ST_RX_WAIT, ST_RX_LO
  } swb_state_e;

  typedef enum logic [1:0] {OP_SEND, OP_RECV, OP_BREAK} swb_op_e;

  localparam logic [4:0] A_REV     = 5'h00;
  localparam logic [4:0] A_TXD     = 5'h04;
  localparam logic [4:0] A_RXD     = 5'h08;
  localparam logic [4:0] A_CTRL    = 5'h0C;
  localparam logic [4:0] A_EVT     = 5'h10;
  localparam logic [4:0] A_SYSCFG  = 5'h14;
  localparam logic [4:0] A_SYSSTAT = 5'h18;

  localparam int B_IE    = 6;
  localparam int B_CLKEN = 5;
  localparam int B_GO    = 4;
  localparam int B_INIT  = 2;
  localparam int B_DIR   = 1;
  localparam int B_MODE  = 0;

  localparam logic [7:0] CTRL_MASK = 8'h77;
  localparam logic [7:0] LIVE_MASK = 8'h61;

  localparam int E_SENT = 2;
  localparam int E_RCVD = 1;
  localparam int E_TMO  = 0;

  localparam int S_SRST  = 1;
  localparam int S_AIDLE = 0;

endpackage

// File: rtl/swb_sync.sv
module swb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  generate
    if (STAGES > 1) begin : g_multi
      assign pipe_d = {pipe_q[STAGES-2:0], d};
    end else begin : g_single
      assign pipe_d = d;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= pipe_d;
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/swb_engine.sv
module swb_engine
  import swb_pkg::*;
#(
  parameter int T_BIT  = 24,
  parameter int T_ONE  = 4,
  parameter int T_ZERO = 16,
  parameter int T_BRK  = 20,
  parameter int T_REC  = 10,
  parameter int RX_TMO = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       start,
  input  swb_op_e    op,
  input  logic [7:0] tx_byte,
  input  logic       line_s,
  output logic       line_pd,
  output logic       busy,
  output logic       fin_sent,
  output logic       fin_rcvd,
  output logic       fin_tmo,
  output logic [7:0] rx_byte
);
  localparam int MAXA   = (T_BIT > T_BRK) ? T_BIT : T_BRK;
  localparam int MAXB   = (T_REC > RX_TMO) ? T_REC : RX_TMO;
  localparam int MAXT   = (MAXA > MAXB) ? MAXA : MAXB;
  localparam int CNT_W  = $clog2(MAXT + 1);
  localparam int THRESH = (T_ONE + T_ZERO) / 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  swb_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [2:0]       idx_q, idx_d;
  logic [7:0]       sh_q, sh_d;

  function automatic logic [CNT_W-1:0] low_len(input logic b);
    return b ? CNT_W'(T_ONE - 1) : CNT_W'(T_ZERO - 1);
  endfunction

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; idx_d = idx_q; sh_d = sh_q;
    fin_sent = 1'b0; fin_rcvd = 1'b0; fin_tmo = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        idx_d = '0;
        unique case (op)
          OP_BREAK: begin st_d = ST_BRK_LO; cnt_d = CNT_W'(T_BRK - 1); end
          OP_RECV:  begin st_d = ST_RX_WAIT; cnt_d = '0; sh_d = '0; end
          default:  begin st_d = ST_TX_LO; sh_d = tx_byte; cnt_d = low_len(tx_byte[0]); end
        endcase
      end
      ST_BRK_LO: if (cnt_q == '0) begin st_d = ST_BRK_HI; cnt_d = CNT_W'(T_REC - 1); end
                 else cnt_d = cnt_q - 1'b1;
      ST_BRK_HI: if (cnt_q == '0) begin st_d = ST_IDLE; fin_tmo = 1'b1; end
                 else cnt_d = cnt_q - 1'b1;
      ST_TX_LO: if (cnt_q == '0) begin
        st_d  = ST_TX_HI;
        cnt_d = sh_q[0] ? CNT_W'(T_BIT - T_ONE - 1) : CNT_W'(T_BIT - T_ZERO - 1);
      end else cnt_d = cnt_q - 1'b1;
      ST_TX_HI: if (cnt_q == '0) begin
        if (idx_q == 3'd7) begin st_d = ST_IDLE; fin_sent = 1'b1; end
        else begin
          st_d = ST_TX_LO; idx_d = idx_q + 1'b1;
          sh_d = {1'b0, sh_q[7:1]}; cnt_d = low_len(sh_q[1]);
        end
      end else cnt_d = cnt_q - 1'b1;
      ST_RX_WAIT: if (!line_s) begin st_d = ST_RX_LO; cnt_d = CNT_W'(1); end
        else if (cnt_q == CNT_W'(RX_TMO - 1)) begin st_d = ST_IDLE; fin_tmo = 1'b1; end
        else cnt_d = cnt_q + 1'b1;
      ST_RX_LO: if (line_s) begin
        sh_d = {(cnt_q < CNT_W'(THRESH)), sh_q[7:1]};
        if (idx_q == 3'd7) begin st_d = ST_IDLE; fin_rcvd = 1'b1; end
        else begin st_d = ST_RX_WAIT; idx_d = idx_q + 1'b1; cnt_d = '0; end
      end else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      default: st_d = ST_IDLE;
    endcase
    if (clr) st_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; idx_q <= '0; sh_q <= '0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; idx_q <= idx_d; sh_q <= sh_d;
    end
  end

  assign line_pd = (st_q == ST_TX_LO) || (st_q == ST_BRK_LO);
  assign busy    = (st_q != ST_IDLE);
  assign rx_byte = sh_d;

  AST_FIN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fin_sent, fin_rcvd, fin_tmo})); // R3
  AST_FIN_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_sent || fin_rcvd || fin_tmo) |=> !busy); // R3
  AST_RX_NO_PULLDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RX_WAIT || st_q == ST_RX_LO) |-> !line_pd); // R5
endmodule

// File: rtl/swb_master.sv
module swb_master
  import swb_pkg::*;
#(
  parameter logic [3:0] REV_MAJOR   = 4'd2,
  parameter logic [3:0] REV_MINOR   = 4'd1,
  parameter int         T_BIT       = 24,
  parameter int         T_ONE       = 4,
  parameter int         T_ZERO      = 16,
  parameter int         T_BRK       = 20,
  parameter int         T_REC       = 10,
  parameter int         RX_TMO      = 64,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       line_in,
  output logic       line_pd,
  output logic       irq
);
  logic [7:0] ctrl_q, ctrl_d, txd_q, rxd_q;
  logic [2:0] evt_q, evt_d;
  logic       aidle_q, aidle_d, srst_q, srst_d;
  logic       wr_ctrl, wr_txd, wr_sys, rd_evt, start, fin_any;
  logic       line_s, eng_busy, fin_sent, fin_rcvd, fin_tmo;
  logic [7:0] rx_byte;
  swb_op_e    op;

  swb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s));

  swb_engine #(.T_BIT(T_BIT), .T_ONE(T_ONE), .T_ZERO(T_ZERO),
               .T_BRK(T_BRK), .T_REC(T_REC), .RX_TMO(RX_TMO)) u_engine (
    .clk(clk), .rst_n(rst_n), .clr(srst_q), .start(start), .op(op),
    .tx_byte(txd_q), .line_s(line_s), .line_pd(line_pd), .busy(eng_busy),
    .fin_sent(fin_sent), .fin_rcvd(fin_rcvd), .fin_tmo(fin_tmo), .rx_byte(rx_byte));

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_txd  = reg_wr && (reg_addr == A_TXD);
  assign wr_sys  = reg_wr && (reg_addr == A_SYSCFG);
  assign rd_evt  = reg_rd && (reg_addr == A_EVT);
  assign fin_any = fin_sent || fin_rcvd || fin_tmo;
  assign start   = wr_ctrl && reg_wdata[B_GO] && reg_wdata[B_CLKEN] && !eng_busy && !srst_q;
  assign op      = reg_wdata[B_INIT] ? OP_BREAK : (reg_wdata[B_DIR] ? OP_RECV : OP_SEND);

  always_comb begin
    ctrl_d  = ctrl_q;
    evt_d   = rd_evt ? 3'b000 : evt_q;
    aidle_d = aidle_q;
    srst_d  = 1'b0;
    if (wr_ctrl) begin
      if (eng_busy) ctrl_d = (ctrl_q & ~LIVE_MASK) | (reg_wdata & LIVE_MASK);
      else          ctrl_d = reg_wdata & CTRL_MASK;
    end
    if (fin_any && ctrl_q[B_IE]) begin
      ctrl_d[B_GO]   = 1'b0;
      ctrl_d[B_INIT] = 1'b0;
    end
    evt_d[E_SENT] = evt_d[E_SENT] | fin_sent;
    evt_d[E_RCVD] = evt_d[E_RCVD] | fin_rcvd;
    evt_d[E_TMO]  = evt_d[E_TMO]  | fin_tmo;
    if (wr_sys) begin
      aidle_d = reg_wdata[S_AIDLE];
      srst_d  = reg_wdata[S_SRST];
    end
    if (srst_q) begin
      ctrl_d = '0; evt_d = '0; aidle_d = 1'b0; srst_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; evt_q <= '0; aidle_q <= 1'b0; srst_q <= 1'b0;
      txd_q  <= '0; rxd_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      evt_q   <= evt_d;
      aidle_q <= aidle_d;
      srst_q  <= srst_d;
      if (srst_q)        txd_q <= '0;
      else if (wr_txd)   txd_q <= reg_wdata;
      if (srst_q)        rxd_q <= '0;
      else if (fin_rcvd) rxd_q <= rx_byte;
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_REV:     reg_rdata = {REV_MAJOR, REV_MINOR};
      A_TXD:     reg_rdata = txd_q;
      A_RXD:     reg_rdata = rxd_q;
      A_CTRL:    reg_rdata = ctrl_q;
      A_EVT:     reg_rdata = {5'b0, evt_q};
      A_SYSCFG:  reg_rdata = {7'b0, aidle_q};
      A_SYSSTAT: reg_rdata = {7'b0, ~srst_q};
      default:   reg_rdata = 8'h00;
    endcase
  end

  assign irq = ctrl_q[B_IE] && (evt_q != 3'b000);

  AST_READ_CLEARS_EVENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !fin_any) |=> (evt_q == 3'b000)); // R7
  AST_GO_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> ctrl_q[B_GO]); // R9
  AST_GO_DROPS_WITH_IE: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_any && ctrl_q[B_IE] && !srst_q) |=> (!ctrl_q[B_GO] && !ctrl_q[B_INIT])); // R9
  AST_GO_KEPT_WITHOUT_IE: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_any && !ctrl_q[B_IE] && !srst_q) |=> ctrl_q[B_GO]); // R9
  AST_SRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (!srst_q && !eng_busy && evt_q == 3'b000)); // R11
endmodule

// File: tb/swb_master_test.sv
module swb_master_test;
  localparam int T_BIT = 24, T_ONE = 4, T_ZERO = 16, T_BRK = 20, T_REC = 10, RX_TMO = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic line_in = 1'b1;
  logic line_pd, irq;

  always #4 clk = ~clk;

  swb_master uut (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .line_in(line_in), .line_pd(line_pd), .irq(irq));

  int n_chk = 0, n_fail = 0, cyc = 0;
  int evt_cyc = -1, busy_end = 0, sr_cyc = -1;
  logic [2:0] evt_val = '0, fl_m = '0;
  logic ie_m = 1'b0;
  logic [7:0] txd_m = '0;
  bit pd_q[$];

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=0x%0h expected=0x%0h at cycle %0d", req, got, exp, cyc);
    end
  endtask

  // reference model: tracks the bus inputs at each edge
  always @(posedge clk) if (rst_n) begin
    cyc++;
    if (sr_cyc == cyc) begin fl_m = '0; ie_m = 1'b0; txd_m = '0; evt_cyc = -1; end
    if (reg_rd && reg_addr == 5'h10) fl_m = '0;
    if (evt_cyc == cyc) fl_m = fl_m | evt_val;
    if (reg_wr && reg_addr == 5'h04) txd_m = reg_wdata;
    if (reg_wr && reg_addr == 5'h14 && reg_wdata[1]) sr_cyc = cyc + 1;
    if (reg_wr && reg_addr == 5'h0C) begin
      ie_m = reg_wdata[6];
      if (reg_wdata[4] && reg_wdata[5] && (cyc - 1 >= busy_end)) begin
        if (reg_wdata[2]) begin
          for (int i = 0; i < T_BRK; i++) pd_q.push_back(1'b1);
          for (int i = 0; i < T_REC; i++) pd_q.push_back(1'b0);
          evt_cyc = cyc + T_BRK + T_REC; evt_val = 3'b001;
        end else if (reg_wdata[1]) begin
          evt_cyc = cyc + RX_TMO; evt_val = 3'b001;
        end else begin
          for (int b = 0; b < 8; b++) begin
            int lo;
            lo = txd_m[b] ? T_ONE : T_ZERO;
            for (int i = 0; i < T_BIT; i++) pd_q.push_back(i < lo);
          end
          evt_cyc = cyc + 8 * T_BIT; evt_val = 3'b100;
        end
        busy_end = evt_cyc;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    bit e;
    e = (pd_q.size() > 0) ? pd_q.pop_front() : 1'b0;
    chk(line_pd == e, "R2 R4 line_pd", line_pd, e);
    chk(irq == (ie_m && fl_m != 0), "R8 irq", irq, (ie_m && fl_m != 0));
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); #1 reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); #1 reg_rd = 1'b1; reg_addr = a;
    #1 chk(reg_rdata == exp, req, reg_rdata, exp);
    @(negedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // slave reply: short low for 1, long low for 0, LSB first
  task automatic slave(input logic [7:0] b, input int gap);
    evt_cyc = -1; busy_end = 1 << 30;
    for (int i = 0; i < 8; i++) begin
      repeat (gap) @(negedge clk);
      #1 line_in = 1'b0;
      repeat (b[i] ? 5 : 15) @(negedge clk);
      #1 line_in = 1'b1;
      if (i == 7) begin evt_cyc = cyc + 3; evt_val = 3'b010; busy_end = cyc + 3; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(5'h00, 8'h21, "R1 revision");
    rd(5'h0C, 8'h00, "R1 control");
    rd(5'h10, 8'h00, "R1 events");
    rd(5'h18, 8'h01, "R1 status");
    // R2 R3 send with interrupt enable
    wr(5'h0C, 8'h60);
    wr(5'h04, 8'hA5);
    wr(5'h0C, 8'h70);
    idle(8 * T_BIT + 6);
    rd(5'h0C, 8'h60, "R9 start cleared with ie");
    rd(5'h10, 8'h04, "R3 send event");
    rd(5'h10, 8'h00, "R7 cleared by read");
    // R9 send with interrupt disabled
    wr(5'h04, 8'h01);
    wr(5'h0C, 8'h30);
    idle(8 * T_BIT + 6);
    rd(5'h0C, 8'h30, "R9 start held without ie");
    rd(5'h10, 8'h04, "R3 send event no ie");
    // R4 break
    wr(5'h0C, 8'h74);
    idle(T_BRK + T_REC + 6);
    rd(5'h0C, 8'h60, "R9 init cleared");
    rd(5'h10, 8'h01, "R4 break event");
    // R5 receive
    wr(5'h0C, 8'h72);
    slave(8'h3C, 6);
    idle(8);
    rd(5'h08, 8'h3C, "R5 received byte");
    rd(5'h10, 8'h02, "R5 receive event");
    rd(5'h0C, 8'h62, "R9 direction kept");
    wr(5'h0C, 8'h72);
    slave(8'hC1, 3);
    idle(8);
    rd(5'h08, 8'hC1, "R5 second byte");
    rd(5'h10, 8'h02, "R5 second event");
    // R6 receive timeout
    wr(5'h0C, 8'h72);
    idle(RX_TMO + 6);
    rd(5'h10, 8'h01, "R6 timeout event");
    // R10 no start without clock enable
    wr(5'h0C, 8'h50);
    idle(30);
    rd(5'h10, 8'h00, "R10 clock enable off");
    // R10 no start while busy
    wr(5'h04, 8'h5A);
    wr(5'h0C, 8'h70);
    idle(10);
    wr(5'h0C, 8'h74);
    idle(8 * T_BIT);
    rd(5'h10, 8'h04, "R10 busy write ignored");
    rd(5'h0C, 8'h60, "R10 control after busy write");
    // R12 autoidle
    wr(5'h14, 8'h01);
    rd(5'h14, 8'h01, "R12 autoidle stored");
    rd(5'h10, 8'h00, "R12 no activity");
    // R11 soft reset with a pending event
    wr(5'h0C, 8'h70);
    idle(8 * T_BIT + 4);
    @(negedge clk); #1 reg_wr = 1'b1; reg_addr = 5'h14; reg_wdata = 8'h02;
    @(negedge clk); #1 reg_wr = 1'b0; reg_rd = 1'b1; reg_addr = 5'h18;
    #1 chk(reg_rdata == 8'h00, "R11 reset busy", reg_rdata, 8'h00);
    @(negedge clk); #2 chk(reg_rdata == 8'h01, "R11 reset done", reg_rdata, 8'h01);
    @(negedge clk); #1 reg_rd = 1'b0;
    rd(5'h0C, 8'h00, "R11 control cleared");
    rd(5'h04, 8'h00, "R11 tx data cleared");
    rd(5'h14, 8'h00, "R11 config cleared");
    rd(5'h10, 8'h00, "R11 events cleared");
    idle(4);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule